// File: doc/BRIEF.md
# Adaptive Test Clock Synchronizer

This block sits on the target side of a boundary-scan debug link. It brings the incoming test clock and its two companion inputs, serial data and mode select, into the core clock domain through a chain of flip-flops clocked by the core clock. The output of the last test clock stage goes straight back to the debugger as the returned clock. A debugger that waits for each edge to come back before it drives the next one is therefore held to a rate the core clock can follow. The fastest rate it can reach is the core clock frequency divided by twice the number of stages.

The serial data and mode select inputs pass through the same number of stages as the test clock, so they reach the core domain in the same cycle as the synchronized clock edge they belong to. One extra register delays the synchronized clock by one more cycle. Comparing the two gives a single-cycle rising-edge strobe and a single-cycle falling-edge strobe, which a TAP controller in the core domain uses in place of the test clock itself.

Top module: `adaptive_tck_sync`

## Requirements
- R1: While reset is low, and right after it is released, every synchronizer stage is 0: the returned clock, the synchronized data and mode outputs and both strobes are low.
- R2: The returned clock equals the level the test clock input held SYNC_STAGES core clock cycles earlier, and it does not yet show a new level one cycle sooner.
- R3: Every level change of the test clock input, held for at least SYNC_STAGES cycles, produces exactly one matching level change on the returned clock.
- R4: The synchronized data output has the same latency of SYNC_STAGES cycles as the returned clock.
- R5: The synchronized mode output has the same latency of SYNC_STAGES cycles as the returned clock.
- R6: The rising-edge strobe is high for exactly one cycle: the first cycle in which the returned clock shows 1 after showing 0.
- R7: The falling-edge strobe is high for exactly one cycle: the first cycle in which the returned clock shows 0 after showing 1.
- R8: The two strobes are never high together, and neither is high while the synchronized clock keeps its level, even if the data or mode inputs change.
- R9: A debugger that toggles the test clock as soon as the returned clock matches it sees a full test clock period of 2·SYNC_STAGES core clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tckIn | input | 1 | Test clock from the debugger |
| tdiIn | input | 1 | Serial test data from the debugger |
| tmsIn | input | 1 | Test mode select from the debugger |
| rtckOut | output | 1 | Returned clock, last test clock synchronizer stage |
| tdiSyncOut | output | 1 | Serial data in the core domain |
| tmsSyncOut | output | 1 | Mode select in the core domain |
| tckRiseOut | output | 1 | One-cycle strobe on a rising synchronized test clock |
| tckFallOut | output | 1 | One-cycle strobe on a falling synchronized test clock |

## Verification
The assertions assume the synchronized test clock can change by at most one level per core cycle, which always holds, and that data and mode are only meaningful when aligned with a clock edge. The stimulus changes the three inputs together, in the cycle after a core clock edge, and holds each combination for at least SYNC_STAGES+1 cycles, so no level is lost in the chain and every expected output falls in a known cycle. The handshake test toggles the test clock only after the returned clock has matched it, just as a throttled debugger does.

// File: rtl/atck_pkg.sv
package atck_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edgeStrobe_t;

  localparam int LANE_TCK = 0;
  localparam int LANE_TDI = 1;
  localparam int LANE_TMS = 2;
  localparam int LANE_COUNT = 3;
endpackage

// File: rtl/atck_datapath.sv
module atck_datapath #(
  parameter int SYNC_STAGES = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic tckIn,
  input  logic tdiIn,
  input  logic tmsIn,
  output logic tckSync,
  output logic tckSyncDly,
  output logic tdiSync,
  output logic tmsSync
);
  import atck_pkg::*;

  localparam int LAST = SYNC_STAGES - 1;

  logic [LANE_COUNT-1:0] laneIn;
  logic [LANE_COUNT-1:0] stageQ [SYNC_STAGES];

  always_comb begin
    laneIn = '0;
    laneIn[LANE_TCK] = tckIn;
    laneIn[LANE_TDI] = tdiIn;
    laneIn[LANE_TMS] = tmsIn;
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= laneIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tckSyncDly <= 1'b0;
    else       tckSyncDly <= stageQ[LAST][LANE_TCK];
  end

  assign tckSync = stageQ[LAST][LANE_TCK];
  assign tdiSync = stageQ[LAST][LANE_TDI];
  assign tmsSync = stageQ[LAST][LANE_TMS];

  // R3: the returned clock moves by at most one level per core cycle and
  // the delayed copy always catches up one cycle later
  assert_dly_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tckSync != tckSyncDly) |=> (tckSyncDly == $past(tckSync)));
endmodule

// File: rtl/atck_edge_ctrl.sv
module atck_edge_ctrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tckSync,
  input  logic                  tckSyncDly,
  output atck_pkg::edgeStrobe_t strobes
);
  always_comb begin
    strobes.rise = tckSync & ~tckSyncDly;
    strobes.fall = ~tckSync & tckSyncDly;
  end

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.rise, strobes.fall}));

  assert_rise_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rise |-> tckSync);

  assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rise |=> !strobes.rise);

  assert_fall_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fall |-> !tckSync);

  assert_fall_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fall |=> !strobes.fall);
endmodule

// File: rtl/adaptive_tck_sync.sv
module adaptive_tck_sync #(
  parameter int SYNC_STAGES = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic tckIn,
  input  logic tdiIn,
  input  logic tmsIn,
  output logic rtckOut,
  output logic tdiSyncOut,
  output logic tmsSyncOut,
  output logic tckRiseOut,
  output logic tckFallOut
);
  import atck_pkg::*;

  logic        tckSync;
  logic        tckSyncDly;
  edgeStrobe_t strobes;

  atck_datapath #(.SYNC_STAGES(SYNC_STAGES)) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .tckIn      (tckIn),
    .tdiIn      (tdiIn),
    .tmsIn      (tmsIn),
    .tckSync    (tckSync),
    .tckSyncDly (tckSyncDly),
    .tdiSync    (tdiSyncOut),
    .tmsSync    (tmsSyncOut)
  );

  atck_edge_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .tckSync    (tckSync),
    .tckSyncDly (tckSyncDly),
    .strobes    (strobes)
  );

  assign rtckOut    = tckSync;
  assign tckRiseOut = strobes.rise;
  assign tckFallOut = strobes.fall;
endmodule

// File: tb/adaptive_tck_sync_tb_top.sv
module adaptive_tck_sync_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 3;
  localparam int NVEC = 8;
  // each entry: {tck, tdi, tms}
  localparam logic [2:0] VECS [NVEC] = '{3'b101, 3'b110, 3'b011, 3'b000,
                                         3'b111, 3'b010, 3'b100, 3'b101};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tckIn = 1'b0, tdiIn = 1'b0, tmsIn = 1'b0;
  logic rtckOut, tdiSyncOut, tmsSyncOut, tckRiseOut, tckFallOut;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adaptive_tck_sync #(.SYNC_STAGES(NS)) dut_i (
    .clk(clk), .rstN(rstN), .tckIn(tckIn), .tdiIn(tdiIn), .tmsIn(tmsIn),
    .rtckOut(rtckOut), .tdiSyncOut(tdiSyncOut), .tmsSyncOut(tmsSyncOut),
    .tckRiseOut(tckRiseOut), .tckFallOut(tckFallOut));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic prevTck;
    int startCyc;
    int cyc;
    int toggles;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "rtck in reset", rtckOut, 0);
    check("R1", "tdiSync in reset", tdiSyncOut, 0);
    check("R1", "tmsSync in reset", tmsSyncOut, 0);
    check("R1", "strobes in reset", {tckRiseOut, tckFallOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "rtck after release", rtckOut, 0);

    // vector table: R2 R3 R4 R5 R6 R7 R8
    prevTck = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {tckIn, tdiIn, tmsIn} = VECS[i];
      repeat (NS - 1) @(negedge clk);
      check("R2", "rtck one cycle early", rtckOut, prevTck);
      @(negedge clk);
      check("R2", "rtck at latency", rtckOut, VECS[i][2]);
      check("R4", "tdiSync at latency", tdiSyncOut, VECS[i][1]);
      check("R5", "tmsSync at latency", tmsSyncOut, VECS[i][0]);
      check("R6", "rise strobe", tckRiseOut, int'(VECS[i][2] & ~prevTck));
      check("R7", "fall strobe", tckFallOut, int'(~VECS[i][2] & prevTck));
      @(negedge clk);
      check("R8", "strobes cleared next cycle", {tckRiseOut, tckFallOut}, 0);
      check("R3", "rtck holds level", rtckOut, VECS[i][2]);
      prevTck = VECS[i][2];
    end

    // R9: throttled handshake, toggle when returned clock matches
    repeat (NS + 1) @(negedge clk);
    cyc = 0; toggles = 0; startCyc = 0;
    while (toggles < 9) begin
      @(negedge clk);
      cyc++;
      if (rtckOut == tckIn) begin
        toggles++;
        if (toggles == 1) startCyc = cyc;
        if (toggles < 9) tckIn = ~tckIn;
      end
    end
    check("R9", "cycles for four periods", cyc - startCyc, 8 * NS);

    // R1: reset mid-run with the chain holding ones
    @(negedge clk);
    {tckIn, tdiIn, tmsIn} = 3'b111;
    repeat (NS + 2) @(negedge clk);
    check("R3", "rtck high before reset", rtckOut, 1);
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "rtck cleared by reset", rtckOut, 0);
    check("R1", "tdiSync cleared by reset", tdiSyncOut, 0);
    check("R1", "tmsSync cleared by reset", tmsSyncOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "no rise strobe at release", tckRiseOut, 0);
    repeat (NS - 1) @(negedge clk);
    check("R6", "rise after reset refill", tckRiseOut, 1);

    finish_run();
  end
endmodule